// File: doc/BRIEF.md
# I2C Target with Pointer-Addressed Register Port

This block is a target on a two-wire serial bus. It runs on the system clock and oversamples the bus clock and data lines through synchronizers. It recognises the start, repeated start and stop conditions. It compares the seven-bit device address of each transfer with a value taken from an input port. On a write, the first byte after the address sets an eight-bit register pointer. Every later byte goes out through a single-cycle write strobe to an external register bank. On a read, the block fetches bytes from the bank at the pointer and shifts them out.

Each of the 256 pointer values is marked usable or unusable by a mask parameter. When the pointer is on a usable location, the block acknowledges the byte and, for writes, stores it. When the pointer is on an unusable location, the block answers not-acknowledge and drops the byte. The pointer advances after every data byte in either direction, regardless of usability, and wraps from 255 to 0. Acknowledging and storing therefore resume by themselves once the pointer reaches a usable location again. The block drives SDA only through an open-drain low enable.

Top module: `i2c_regport`

## Requirements
- R1: While reset is high and right after it falls, `sda_oe` and `reg_we` are low, and the bus data line reads high.
- R2: A high-to-low data edge while the clock is high starts an address phase, including a repeated start with no stop before it. A low-to-high data edge while the clock is high ends the transfer. A byte cut short by a stop is never written.
- R3: The first byte after a start carries the 7-bit device address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). It is acknowledged only when bits 7..1 equal `dev_addr`. On a mismatch the block neither drives SDA nor writes until the next start.
- R4: In a write, the byte after the address byte loads the pointer. It is acknowledged exactly when bit `p` of `VALID_MASK` is 1, where `p` is the loaded value.
- R5: A write data byte at pointer `p` produces one `reg_we` pulse with `reg_addr = p` and the byte on `reg_wdata`, and is acknowledged, when mask bit `p` is 1. Otherwise it is not acknowledged and nothing is written.
- R6: The pointer advances by one after every data byte, written or read, usable or not, and wraps from 255 to 0.
- R7: In a read, the block sends the bank content at the pointer, MSB first. While the controller acknowledges, each following byte comes from the next pointer value.
- R8: After the controller answers a read byte with not-acknowledge, the block releases SDA and keeps it released until the next start.
- R9: `sda_oe` is high only during the acknowledge slot of a byte the block accepts, or during the data bits of a read byte.
- R10: `sda_oe` changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 7 | Device address this target answers to |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain pull-low enable for the data line |
| reg_we | output | 1 | One-cycle write strobe to the register bank |
| reg_addr | output | 8 | Current register pointer, used for reads and writes |
| reg_wdata | output | 8 | Byte to store when `reg_we` is high |
| reg_rdata | input | 8 | Bank content at `reg_addr` |

## Verification
The bench drives write bursts whose pointer passes from usable into unusable locations and back again. These show whether the acknowledge and the store follow the validity of each byte's own pointer rather than the validity of the starting pointer. A burst across 255 to 0 separates correct wrapping from a pointer that saturates or skips. Reads that start on chosen locations and end with a not-acknowledge check byte order, pointer advance and the release of the line. Transfers with a wrong address, a stop in the middle of a byte, a repeated start between writes and a changed `dev_addr` show whether the bus conditions reset the address phase and whether a discarded byte stays out of the bank.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_PTR,
    BY_DATA
  } rx_kind_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic cond_start,
  output logic cond_stop
);

  assign cond_start = scl_lvl & sda_fall;
  assign cond_stop  = scl_lvl & sda_rise;

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_regport_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [(1<<PTR_W)-1:0] VALID_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        dev_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata
);

  localparam int DA_W  = 7;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  tgt_state_e        st_q;
  rx_kind_e          kind_q;
  logic              rd_q;
  logic              mack_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] tx_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_nxt;
  logic              oe_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;

  logic byte_done;
  logic addr_hit;
  logic ptr_ok;
  logic load_ok;
  logic ptr_load;

  assign ptr_nxt   = ptr_q + 1'b1;
  assign byte_done = (st_q == ST_RX) && scl_fall && (cnt_q == CNT_FULL);
  assign addr_hit  = (sh_q[DATA_W-1 -: DA_W] == dev_addr);
  assign ptr_ok    = VALID_MASK[ptr_q];
  assign load_ok   = VALID_MASK[sh_q[PTR_W-1:0]];
  assign ptr_load  = byte_done && (kind_q == BY_PTR) && !bus_start && !bus_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      kind_q <= BY_ADDR;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      oe_q   <= 1'b0;
      we_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      we_q <= 1'b0;
      if (bus_start) begin
        st_q   <= ST_RX;
        kind_q <= BY_ADDR;
        cnt_q  <= '0;
        oe_q   <= 1'b0;
      end else if (bus_stop) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[DATA_W-2:0], sda_s};
              cnt_q <= cnt_q + CNT_ONE;
            end else if (byte_done) begin
              cnt_q <= '0;
              unique case (kind_q)
                BY_ADDR: begin
                  if (addr_hit) begin
                    st_q <= ST_ACK;
                    oe_q <= 1'b1;
                    rd_q <= sh_q[0];
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                BY_PTR: begin
                  ptr_q <= sh_q[PTR_W-1:0];
                  st_q  <= ST_ACK;
                  oe_q  <= load_ok;
                end
                default: begin
                  st_q <= ST_ACK;
                  oe_q <= ptr_ok;
                  we_q <= ptr_ok;
                  wd_q <= sh_q;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              oe_q <= 1'b0;
              unique case (kind_q)
                BY_ADDR: begin
                  if (rd_q) begin
                    st_q  <= ST_TX;
                    tx_q  <= reg_rdata;
                    oe_q  <= ~reg_rdata[DATA_W-1];
                    cnt_q <= '0;
                  end else begin
                    st_q   <= ST_RX;
                    kind_q <= BY_PTR;
                  end
                end
                BY_PTR: begin
                  st_q   <= ST_RX;
                  kind_q <= BY_DATA;
                end
                default: begin
                  st_q  <= ST_RX;
                  ptr_q <= ptr_nxt;
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == CNT_LAST) begin
                st_q  <= ST_RACK;
                oe_q  <= 1'b0;
                ptr_q <= ptr_nxt;
              end else begin
                cnt_q <= cnt_q + CNT_ONE;
                tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
                oe_q  <= ~tx_q[DATA_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                st_q  <= ST_TX;
                tx_q  <= reg_rdata;
                oe_q  <= ~reg_rdata[DATA_W-1];
                cnt_q <= '0;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wd_q;

  // R10: the pull-low enable only moves in a cycle that saw the bus clock low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    (oe_q != $past(oe_q)) |-> !$past(scl_s));

  // R3: an ignoring target stays silent
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (!oe_q && !we_q));

  // R5: stores only land on usable locations, one strobe per byte
  p_we_usable_r5: assert property (@(posedge clk) disable iff (rst)
    we_q |-> VALID_MASK[ptr_q]);
  p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
    we_q |=> !we_q);

  // R6: outside a pointer load the pointer only steps by one
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
    ((ptr_q != $past(ptr_q)) && !$past(ptr_load)) |-> (ptr_q == $past(ptr_nxt)));

  // R8: line released while waiting for the controller's answer
  p_rack_release_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RACK) |-> !oe_q);

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter int PTR_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [(1<<PTR_W)-1:0] VALID_MASK = {{((1<<PTR_W)-64){1'b0}}, {64{1'b1}}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        dev_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int N_LINES = 2;
  localparam int L_SCL   = 0;
  localparam int L_SDA   = 1;

  logic [N_LINES-1:0] raw;
  logic [N_LINES-1:0] lvl;
  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] fall;
  logic               cond_start;
  logic               cond_stop;

  assign raw[L_SCL] = scl_i;
  assign raw[L_SDA] = sda_i;

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .line_i  (raw[g]),
      .level_o (lvl[g]),
      .rise_o  (rise[g]),
      .fall_o  (fall[g])
    );
  end

  i2c_bus_cond u_cond (
    .scl_lvl    (lvl[L_SCL]),
    .sda_rise   (rise[L_SDA]),
    .sda_fall   (fall[L_SDA]),
    .cond_start (cond_start),
    .cond_stop  (cond_stop)
  );

  i2c_target_ctrl #(
    .PTR_W      (PTR_W),
    .DATA_W     (DATA_W),
    .VALID_MASK (VALID_MASK)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .dev_addr  (dev_addr),
    .scl_s     (lvl[L_SCL]),
    .sda_s     (lvl[L_SDA]),
    .scl_rise  (rise[L_SCL]),
    .scl_fall  (fall[L_SCL]),
    .bus_start (cond_start),
    .bus_stop  (cond_stop),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
  );

endmodule

// File: tb/sim_i2c_regport.sv
module sim_i2c_regport;

  localparam int Q = 10;

  function automatic bit usable(int p);
    return (p < 16) || (p >= 32 && p < 48) || (p >= 252);
  endfunction

  function automatic logic [255:0] build_mask();
    logic [255:0] m;
    for (int i = 0; i < 256; i++) m[i] = usable(i);
    return m;
  endfunction

  localparam logic [255:0] TB_MASK = build_mask();

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] dev_addr = 7'h3A;
  logic       scl = 1'b1;
  logic       sda_low = 1'b0;
  logic       may_drive = 1'b0;
  logic       oe_prev = 1'b0;
  logic       done = 1'b0;
  logic       sda_oe;
  logic       reg_we;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  wire        sda_bus = ~(sda_low | sda_oe);

  logic [7:0] bank [256];
  logic [7:0] exp_mem [256];
  int vectors = 0;
  int errs = 0;

  always #5 clk = ~clk;

  i2c_regport #(.VALID_MASK(TB_MASK)) u0 (
    .clk       (clk),
    .rst       (rst),
    .dev_addr  (dev_addr),
    .scl_i     (scl),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;
  assign reg_rdata = bank[reg_addr];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every-clock comparison against the allowed drive window (R9) and edge rule (R10)
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (sda_oe && !may_drive) begin
        errs++;
        $display("FAIL R9 sda_oe outside a drive slot actual=1 expected=0 at %0t", $time);
      end
      if ((sda_oe != oe_prev) && scl) begin
        errs++;
        $display("FAIL R10 sda_oe moved with clock high actual=%0b expected=%0b", sda_oe, oe_prev);
      end
    end
    oe_prev = sda_oe;
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_low = 1'b0; wt(2);
    scl = 1'b1; wt(Q);
    sda_low = 1'b1; wt(Q);
    scl = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    sda_low = 1'b1; wt(2);
    scl = 1'b1; wt(Q);
    sda_low = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit keep, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_low = !b[i]; wt(Q);
      scl = 1'b1; wt(Q);
      if (i == 0) may_drive = 1'b1;
      scl = 1'b0; wt(2);
    end
    sda_low = 1'b0; wt(Q);
    scl = 1'b1; wt(Q/2);
    ack = (sda_bus == 1'b0);
    wt(Q/2);
    scl = 1'b0; wt(6);
    if (!keep) may_drive = 1'b0;
  endtask

  task automatic recv_byte(input bit ackv, output logic [7:0] d);
    d = '0;
    sda_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wt(Q);
      scl = 1'b1; wt(Q/2);
      d = {d[6:0], sda_bus};
      wt(Q/2);
      scl = 1'b0; wt(2);
    end
    wt(4);
    may_drive = 1'b0;
    sda_low = ackv; wt(Q);
    scl = 1'b1; wt(Q);
    if (ackv) may_drive = 1'b1;
    scl = 1'b0; wt(2);
    sda_low = 1'b0;
  endtask

  task automatic bank_chk(string req);
    int bad = -1;
    for (int i = 0; i < 256; i++) if (bad < 0 && bank[i] !== exp_mem[i]) bad = i;
    if (bad < 0) chk(1'b1, req, "bank", 0, 0);
    else chk(1'b0, req, $sformatf("bank[%0h]", bad), bank[bad], exp_mem[bad]);
  endtask

  task automatic addr_ptr(input logic [7:0] p);
    bit a;
    send_byte({dev_addr, 1'b0}, 1'b0, a);
    chk(a, "R3", "address ack", a, 1);
    send_byte(p, 1'b0, a);
    chk(a == usable(p), "R4", $sformatf("pointer %0h ack", p), a, usable(p));
  endtask

  task automatic write_burst(input logic [7:0] p, input int n, input logic [7:0] seed);
    logic [7:0] mp;
    logic [7:0] d;
    bit a;
    mp = p;
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 37);
      send_byte(d, 1'b0, a);
      chk(a == usable(mp), "R5", $sformatf("data ack at %0h", mp), a, usable(mp));
      if (usable(mp)) exp_mem[mp] = d;
      mp = mp + 8'd1;   // R6: advances on every byte
    end
  endtask

  task automatic do_write(input logic [7:0] p, input int n, input logic [7:0] seed);
    bus_start();
    addr_ptr(p);
    write_burst(p, n, seed);
    bus_stop();
    bank_chk("R5/R6 write burst");
  endtask

  task automatic do_read(input logic [7:0] p, input int n);
    logic [7:0] mp;
    logic [7:0] d;
    bit a;
    bus_start();
    addr_ptr(p);
    bus_start();
    send_byte({dev_addr, 1'b1}, 1'b1, a);
    chk(a, "R3", "read address ack", a, 1);
    mp = p;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(d == exp_mem[mp], "R7", $sformatf("read byte at %0h", mp), d, exp_mem[mp]);
      mp = mp + 8'd1;   // R6 on reads
    end
    wt(20);
    chk(!sda_oe && sda_bus, "R8", "line released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      bank[i] = 8'(i) ^ 8'hA5;
      exp_mem[i] = 8'(i) ^ 8'hA5;
    end
    wt(5);
    chk(!sda_oe && !reg_we, "R1", "outputs in reset", {sda_oe, reg_we}, 0);
    rst = 1'b0;
    wt(3);
    chk(!sda_oe && !reg_we && sda_bus, "R1", "outputs after reset", {sda_oe, reg_we}, 0);

    // R3: wrong address, bytes that follow are ignored
    begin
      bit a;
      bus_start();
      send_byte({7'h15, 1'b0}, 1'b0, a);
      chk(!a, "R3", "mismatch nack", a, 0);
      send_byte(8'h02, 1'b0, a);
      chk(!a, "R3", "ignored byte 1", a, 0);
      send_byte(8'h77, 1'b0, a);
      chk(!a, "R3", "ignored byte 2", a, 0);
      bus_stop();
      bank_chk("R3 no write after mismatch");
    end

    // usable -> unusable -> usable crossing
    do_write(8'h0C, 26, 8'h11);
    // start on an unusable pointer, resume at 0x20
    do_write(8'h1D, 6, 8'h40);
    // wrap 255 -> 0
    do_write(8'hFD, 5, 8'h90);

    do_read(8'h0E, 4);
    do_read(8'hFE, 3);
    do_read(8'h2E, 4);

    // R2: stop in the middle of a data byte drops it
    begin
      bit a;
      bus_start();
      addr_ptr(8'h03);
      for (int i = 7; i >= 4; i--) begin
        sda_low = !(8'hC3 >> i & 1); wt(Q);
        scl = 1'b1; wt(Q);
        scl = 1'b0; wt(2);
      end
      bus_stop();
      bank_chk("R2 partial byte dropped");
      chk(!sda_oe, "R2", "idle after stop", sda_oe, 0);
    end

    // R2: repeated start between two write transfers
    bus_start();
    addr_ptr(8'h02);
    write_burst(8'h02, 1, 8'h5C);
    bus_start();
    addr_ptr(8'h08);
    write_burst(8'h08, 2, 8'h6D);
    bus_stop();
    bank_chk("R2 repeated start write");

    // R3: new device address from the port
    dev_addr = 7'h51;
    wt(4);
    do_write(8'h24, 3, 8'h33);
    do_read(8'h24, 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R2 watchdog expired actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

endmodule